// File: doc/BRIEF.md
# Local Exclusive Reservation Monitor

This block sits beside one processor's load/store unit and holds a single reservation for load-exclusive/store-exclusive synchronization. A load-exclusive arms the reservation and records the granule-aligned address it touched. A later store-exclusive is granted only if the reservation is still armed and its address falls in the same granule. The grant or refusal comes back in the same cycle as the request, so the core can hold back the memory write and load the status register. Every store-exclusive, whether granted or not, drops the reservation. A clear-exclusive command or an exception boundary also drops it, without any memory transaction.

The monitor is a two-state machine (open, armed) plus an address tag register. The tag keeps only the bits above the reservation granule. The granule size, the address width and the effect of ordinary stores are all parameters. By default an ordinary store leaves the reservation alone. A variant can be selected in which an ordinary store to the reserved granule drops it.

When several events arrive in one cycle, they are ordered as follows. A clear or exception beats everything. Next comes a load-exclusive, which arms. Then a store-exclusive, which disarms. An ordinary store comes last. A store-exclusive is always judged against the state held before the current edge.

Top module: `excl_resv_monitor`

## Requirements
- R1: After reset the monitor is open (`resv_armed`=0) and `resv_tag` is 0.
- R2: A load-exclusive with no clear in the same cycle makes `resv_armed` 1 from the next cycle. `resv_tag` then holds the load address with its low GRAN_LOG2 bits forced to 0.
- R3: In the cycle of a store-exclusive, `sx_fail` is 0 (success) when the monitor is armed and the store address matches the tag above the granule. Otherwise `sx_fail` is 1. `sx_fail` is 0 in cycles with no store-exclusive.
- R4: A store-exclusive with no load-exclusive in the same cycle leaves the monitor open from the next cycle, whether it succeeded or failed.
- R5: A clear-exclusive command opens the monitor from the next cycle and leaves `resv_tag` unchanged.
- R6: An exception boundary pulse opens the monitor from the next cycle.
- R7: A load-exclusive while already armed replaces the tag with the new granule address. A store-exclusive to the old granule then fails.
- R8: With the default PLAIN_ST_CLEARS=0, an ordinary store has no effect on `resv_armed` or `resv_tag`, even when it targets the reserved granule.
- R9: A clear-exclusive or exception in the same cycle as a store-exclusive makes that store fail, and the monitor is open afterwards. It also cancels a same-cycle load-exclusive.
- R10: Two addresses that differ only in bits below GRAN_LOG2 fall in the same granule. Addresses that differ in any higher bit do not.
- R11: With a load-exclusive and a store-exclusive in the same cycle, the store is judged on the prior state and the new load's reservation is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lx_valid | input | 1 | Load-exclusive event |
| lx_addr | input | ADDR_W | Load-exclusive physical address |
| sx_valid | input | 1 | Store-exclusive event |
| sx_addr | input | ADDR_W | Store-exclusive physical address |
| st_valid | input | 1 | Ordinary store event |
| st_addr | input | ADDR_W | Ordinary store address |
| clr_excl | input | 1 | Clear-exclusive command |
| exc_edge | input | 1 | Exception entry or exit pulse |
| sx_fail | output | 1 | Store-exclusive status, 0 success, 1 failure (same cycle) |
| resv_armed | output | 1 | Monitor state, 1 armed, 0 open |
| resv_tag | output | ADDR_W | Granule-aligned reserved address |

## Verification
Directed sequences try store-exclusive after a matching load and after a load to a neighbouring granule. They also try it with the low offset changed inside the granule and when the monitor is open. Together these separate tag comparison, granule masking and state gating. Further sequences put clear, exception, load-exclusive and ordinary store in the same cycle as a store-exclusive, which exposes a wrong priority order. A long pseudo-random stream over a handful of nearby addresses is compared every cycle with a behavioural model, to catch interactions the directed cases miss.

// File: rtl/excl_mon_pkg.sv
package excl_mon_pkg;
   typedef enum logic {
      RESV_OPEN  = 1'b0,
      RESV_ARMED = 1'b1
   } resv_state_t;
endpackage

// File: rtl/excl_granule_tag.sv
module excl_granule_tag #(
   parameter int ADDR_W    = 32,
   parameter int GRAN_LOG2 = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_addr,
   input  logic [ADDR_W-1:0] probe_a,
   input  logic [ADDR_W-1:0] probe_b,
   output logic [ADDR_W-1:0] tag,
   output logic              hit_a,
   output logic              hit_b
);
   localparam logic [ADDR_W-1:0] LOW_MASK = (ADDR_W'(1) << GRAN_LOG2) - ADDR_W'(1);
   localparam logic [ADDR_W-1:0] KEEP     = ~LOW_MASK;

   logic [ADDR_W-1:0] tag_q;

   always_ff @(posedge clk) begin
      if (!rst_n)     tag_q <= '0;
      else if (load)  tag_q <= load_addr & KEEP;
   end

   assign tag   = tag_q;
   assign hit_a = ((probe_a & KEEP) == tag_q);
   assign hit_b = ((probe_b & KEEP) == tag_q);

   // R1/R10: the stored tag never carries bits below the granule
   a_r10_tag_aligned: assert property (@(posedge clk) disable iff (!rst_n)
      (tag_q & LOW_MASK) == '0);
   // R5: the tag only moves on a load
   a_r5_tag_held: assert property (@(posedge clk) disable iff (!rst_n)
      !load |=> $stable(tag_q));
endmodule

// File: rtl/excl_state_ctl.sv
module excl_state_ctl
   import excl_mon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic arm,
   input  logic disarm,
   output logic armed
);
   resv_state_t st_q, st_d;

   always_comb begin
      st_d = st_q;
      if (arm)         st_d = RESV_ARMED;
      else if (disarm) st_d = RESV_OPEN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= RESV_OPEN;
      else        st_q <= st_d;
   end

   assign armed = (st_q == RESV_ARMED);

   a_r2_arm_takes: assert property (@(posedge clk) disable iff (!rst_n)
      arm |=> armed);
   a_r4_disarm_takes: assert property (@(posedge clk) disable iff (!rst_n)
      (disarm && !arm) |=> !armed);
endmodule

// File: rtl/excl_resv_monitor.sv
module excl_resv_monitor #(
   parameter int ADDR_W          = 32,
   parameter int GRAN_LOG2       = 3,
   parameter bit PLAIN_ST_CLEARS = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lx_valid,
   input  logic [ADDR_W-1:0] lx_addr,
   input  logic              sx_valid,
   input  logic [ADDR_W-1:0] sx_addr,
   input  logic              st_valid,
   input  logic [ADDR_W-1:0] st_addr,
   input  logic              clr_excl,
   input  logic              exc_edge,
   output logic              sx_fail,
   output logic              resv_armed,
   output logic [ADDR_W-1:0] resv_tag
);
   if (ADDR_W < 2) begin : g_bad_width
      $error("ADDR_W must be at least 2");
   end
   if (GRAN_LOG2 < 0 || GRAN_LOG2 >= ADDR_W) begin : g_bad_gran
      $error("GRAN_LOG2 must lie in 0..ADDR_W-1");
   end

   logic drop_all, arm, disarm, sx_hit, st_hit, st_drop, armed_q;

   assign drop_all = clr_excl | exc_edge;
   assign arm      = lx_valid & ~drop_all;

   excl_granule_tag #(.ADDR_W(ADDR_W), .GRAN_LOG2(GRAN_LOG2)) u_tag (
      .clk(clk), .rst_n(rst_n),
      .load(arm), .load_addr(lx_addr),
      .probe_a(sx_addr), .probe_b(st_addr),
      .tag(resv_tag), .hit_a(sx_hit), .hit_b(st_hit)
   );

   if (PLAIN_ST_CLEARS) begin : g_st_drops
      assign st_drop = st_valid & st_hit;
   end else begin : g_st_ignored
      assign st_drop = 1'b0;
      // R8: ordinary stores alone leave the state untouched
      a_r8_plain_store_inert: assert property (@(posedge clk) disable iff (!rst_n)
         (st_valid && !lx_valid && !sx_valid && !drop_all) |=> $stable(resv_armed));
   end

   assign disarm = drop_all | sx_valid | st_drop;

   excl_state_ctl u_fsm (
      .clk(clk), .rst_n(rst_n),
      .arm(arm), .disarm(disarm), .armed(armed_q)
   );

   assign resv_armed = armed_q;
   assign sx_fail    = sx_valid & (drop_all | ~armed_q | ~sx_hit);

   a_r3_open_fails: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && !resv_armed) |-> sx_fail);
   a_r3_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !sx_valid |-> !sx_fail);
   a_r9_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && drop_all) |-> sx_fail);
   a_r6_clear_opens: assert property (@(posedge clk) disable iff (!rst_n)
      drop_all |=> !resv_armed);
   a_r4_store_opens: assert property (@(posedge clk) disable iff (!rst_n)
      (sx_valid && !lx_valid) |=> !resv_armed);
endmodule

// File: tb/tb_excl_resv_monitor.sv
module tb_excl_resv_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int GL = 3;

   logic clk = 1'b0, rst_n = 1'b0;
   logic lx_valid = 0, sx_valid = 0, st_valid = 0, clr_excl = 0, exc_edge = 0;
   logic [AW-1:0] lx_addr = '0, sx_addr = '0, st_addr = '0;
   logic sx_fail, resv_armed;
   logic [AW-1:0] resv_tag;

   int errors = 0, checks = 0, cycles = 0;
   bit m_armed = 0;
   logic [AW-1:0] m_tag = '0;

   always #(CLK_PERIOD/2) clk = ~clk;

   excl_resv_monitor dut (.*);

   function automatic logic [AW-1:0] gran(input logic [AW-1:0] a);
      return (a >> GL) << GL;
   endfunction

   task automatic check(input string req, input logic [AW-1:0] act, input logic [AW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h (t=%0t)", req, act, exp, $time);
      end
   endtask

   // drive one cycle at negedge, compare to model, then advance model at posedge
   task automatic step(input bit lx, input logic [AW-1:0] la, input bit sx, input logic [AW-1:0] sa,
                       input bit st, input logic [AW-1:0] ta, input bit clr, input bit exc,
                       input string req);
      bit drop, exp_fail;
      @(negedge clk);
      lx_valid = lx; lx_addr = la; sx_valid = sx; sx_addr = sa;
      st_valid = st; st_addr = ta; clr_excl = clr; exc_edge = exc;
      #1;
      drop = clr | exc;
      exp_fail = sx && (drop || !m_armed || gran(sa) != m_tag);
      check({req, " sx_fail"}, AW'(sx_fail), AW'(exp_fail));
      check({req, " armed"}, AW'(resv_armed), AW'(m_armed));
      check({req, " tag"}, resv_tag, m_tag);
      @(posedge clk);
      if (drop) m_armed = 0;
      else if (lx) begin m_armed = 1; m_tag = gran(la); end
      else if (sx) m_armed = 0;
   endtask

   task automatic idle(input string req);
      step(0, '0, 0, '0, 0, '0, 0, 0, req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++; checks++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1'b1;
      idle("R1 reset");
      // R2 load arms, tag aligned
      step(1, 32'h1000_0015, 0, '0, 0, '0, 0, 0, "R2 load");
      idle("R2 armed");
      // R3 matching store passes, R4 opens after
      step(0, '0, 1, 32'h1000_0010, 0, '0, 0, 0, "R3 match pass");
      idle("R4 open after pass");
      // R3 store while open fails
      step(0, '0, 1, 32'h1000_0010, 0, '0, 0, 0, "R3 open fail");
      // R10 offset within granule matches; other granule fails
      step(1, 32'h2000_0040, 0, '0, 0, '0, 0, 0, "R10 load");
      step(0, '0, 1, 32'h2000_0047, 0, '0, 0, 0, "R10 same granule");
      step(1, 32'h2000_0040, 0, '0, 0, '0, 0, 0, "R10 reload");
      step(0, '0, 1, 32'h2000_0048, 0, '0, 0, 0, "R10 next granule");
      idle("R4 open after fail");
      // R7 replace tag
      step(1, 32'h3000_0000, 0, '0, 0, '0, 0, 0, "R7 first");
      step(1, 32'h3000_0100, 0, '0, 0, '0, 0, 0, "R7 second");
      step(0, '0, 1, 32'h3000_0000, 0, '0, 0, 0, "R7 old fails");
      // R5 clear keeps tag
      step(1, 32'h4000_0020, 0, '0, 0, '0, 0, 0, "R5 load");
      step(0, '0, 0, '0, 0, '0, 1, 0, "R5 clear");
      idle("R5 opened");
      step(0, '0, 1, 32'h4000_0020, 0, '0, 0, 0, "R5 store after clear");
      // R6 exception
      step(1, 32'h5000_0000, 0, '0, 0, '0, 0, 0, "R6 load");
      step(0, '0, 0, '0, 0, '0, 0, 1, "R6 exception");
      step(0, '0, 1, 32'h5000_0000, 0, '0, 0, 0, "R6 store after exc");
      // R8 plain store to reserved granule does nothing
      step(1, 32'h6000_0008, 0, '0, 0, '0, 0, 0, "R8 load");
      step(0, '0, 0, '0, 1, 32'h6000_0008, 0, 0, "R8 plain store");
      idle("R8 still armed");
      step(0, '0, 1, 32'h6000_000c, 0, '0, 0, 0, "R8 sx passes");
      // R9 clear with store-exclusive
      step(1, 32'h7000_0000, 0, '0, 0, '0, 0, 0, "R9 load");
      step(0, '0, 1, 32'h7000_0000, 0, '0, 1, 0, "R9 clear+sx");
      step(1, 32'h7000_0000, 0, '0, 0, '0, 0, 0, "R9 reload");
      step(1, 32'h7000_0100, 1, 32'h7000_0000, 0, '0, 0, 1, "R9 exc+sx+lx");
      idle("R9 open");
      // R11 load and store same cycle
      step(1, 32'h8000_0000, 0, '0, 0, '0, 0, 0, "R11 load");
      step(1, 32'h8000_0200, 1, 32'h8000_0000, 0, '0, 0, 0, "R11 lx+sx");
      idle("R11 new reservation");
      step(0, '0, 1, 32'h8000_0200, 0, '0, 0, 0, "R11 sx new tag");
      // random mix over a few nearby addresses
      for (int i = 0; i < 2000; i++) begin
         logic [AW-1:0] a1, a2, a3;
         int r;
         r  = $urandom;
         a1 = 32'h9000_0000 + AW'($urandom_range(0, 31));
         a2 = 32'h9000_0000 + AW'($urandom_range(0, 31));
         a3 = 32'h9000_0000 + AW'($urandom_range(0, 31));
         step(r[1:0] == 0, a1, r[3:2] == 0, a2, r[5:4] == 0, a3,
              r[9:6] == 0, r[13:10] == 0, "R3 random");
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule